// File: doc/BRIEF.md
# Programmable Burst Pulse Generator

This block emits a finite or endless train of rectangular pulses on one output. Two 16-bit configuration words set the pulse shape. One word holds the repetition interval and the high time. The other holds the number of pulses and a 2-bit code that picks the time step. A single prescaler turns the system clock into step ticks at one of four programmable ratios. With the default ratios and a 40 MHz clock, the steps are 25 ns, 1.6 µs, 400 µs and 104 ms.

A burst begins on a start event. The start can come from a software strobe, a short press of a front-panel button, either of two external inputs, or the OR of both inputs. A 2-bit selector picks the source. The external inputs and the button pass through two-flop synchronisers, and starts are taken on rising edges. A stop input, held high, ends any running burst and blocks new ones. A busy flag shows when a burst is running. The configuration is captured when a burst starts, so writes made during a burst apply only to the next one.

Top module: `burst_pulser`

## Requirements
- R1: A write with `cfg_we` high and `cfg_addr` 0 loads the shape word: interval in bits 15:8, high time in bits 7:0. With `cfg_addr` 1 it loads the count word: pulse count in bits 15:8, step code in bits 1:0. Both words reset to zero.
- R2: Step code 0, 1, 2 and 3 makes one step last STEP_DIV0, STEP_DIV1, STEP_DIV2 and STEP_DIV3 clock cycles. The defaults are 1, 64, 16000 and 4160000.
- R3: In every interval the output is high for the first high-time steps and low for the rest. A high time at or above the interval keeps the output high for the whole interval. An interval value of 0 acts as 1 step.
- R4: `busy` stays high for exactly count × interval steps from the cycle after the start is accepted. After that, `busy` and `pulse_out` are low.
- R5: A pulse count of 0 repeats the interval without end, until a stop.
- R6: `start_sel` picks the start source: 0 = software strobe `sw_start` or a short button press, 1 = `in0`, 2 = `in1`, 3 = `in0` OR `in1`. An input rise is seen through two flops: `busy` is high after the third rising clock edge following the input change. A `sw_start` strobe gives `busy` after the next edge.
- R7: A button press whose synchronised high time is shorter than LONG_PRESS cycles starts a burst on release when `start_sel` is 0. A press of LONG_PRESS cycles or longer starts nothing.
- R8: A start event while `busy` is high is ignored, and the running burst keeps its length.
- R9: After `stop_in` rises, `busy` and `pulse_out` are low after the third rising edge. While `stop_in` stays high, every start is ignored.
- R10: Configuration writes made while `busy` is high do not change the running burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 1 | Word select: 0 shape, 1 count/step |
| cfg_wdata | input | 16 | Configuration write data |
| start_sel | input | 2 | Start source code |
| sw_start | input | 1 | One-cycle software start strobe |
| button | input | 1 | Raw button level, high while pressed |
| in0 | input | 1 | Asynchronous start input 0 |
| in1 | input | 1 | Asynchronous start input 1 |
| stop_in | input | 1 | Asynchronous stop level |
| pulse_out | output | 1 | Pulse train output |
| busy | output | 1 | High while a burst runs |

## Verification
A wrong step count or a wrong phase counter changes where the edges of `pulse_out` fall. The bench compares `pulse_out` and `busy` against its own model on every cycle of a burst, so such a fault shows within one interval. A wrong burst counter moves the fall of `busy`, which is caught in the final cycle of the burst. Faults in the synchroniser, the source selection and the button timer show up as the wrong start latency, or as a burst that starts or fails to start within a few cycles of the stimulus.

// File: rtl/burst_pulser_pkg.sv
package burst_pulser_pkg;

  typedef enum logic [1:0] {
    SRC_MANUAL = 2'b00,
    SRC_IN0    = 2'b01,
    SRC_IN1    = 2'b10,
    SRC_EITHER = 2'b11
  } start_src_e;

  typedef struct packed {
    logic [7:0] interval;
    logic [7:0] high_time;
  } shape_word_t;

  typedef struct packed {
    logic [7:0] count;
    logic [1:0] step_code;
  } burst_word_t;

  // interval of zero is treated as one step
  function automatic logic [7:0] eff_interval(input logic [7:0] iv);
    return (iv == 8'd0) ? 8'd1 : iv;
  endfunction

  // output level for a given phase within the interval
  function automatic logic phase_level(input logic [7:0] phase, input logic [7:0] high_time);
    return phase < high_time;
  endfunction

  function automatic logic pick_start(input start_src_e sel, input logic manual,
                                      input logic r0, input logic r1);
    case (sel)
      SRC_MANUAL: return manual;
      SRC_IN0:    return r0;
      SRC_IN1:    return r1;
      default:    return r0 | r1;
    endcase
  endfunction

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/bp_sync_pair.sv
module bp_sync_pair #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] lvl,
  output logic [N-1:0] lvl_d
);
  logic [N-1:0] meta;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta[i]  <= 1'b0;
        lvl[i]   <= 1'b0;
        lvl_d[i] <= 1'b0;
      end else begin
        meta[i]  <= d[i];
        lvl[i]   <= meta[i];
        lvl_d[i] <= lvl[i];
      end
    end
  end
endmodule

// File: rtl/bp_step_gen.sv
module bp_step_gen #(
  parameter int DIV0 = 1,
  parameter int DIV1 = 64,
  parameter int DIV2 = 16000,
  parameter int DIV3 = 4160000,
  parameter int CW   = 22
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       en,
  input  logic [1:0] step_code,
  output logic       tick
);
  logic [CW-1:0] pre;
  logic [CW-1:0] last_val;

  always_comb begin
    case (step_code)
      2'd0:    last_val = CW'(DIV0 - 1);
      2'd1:    last_val = CW'(DIV1 - 1);
      2'd2:    last_val = CW'(DIV2 - 1);
      default: last_val = CW'(DIV3 - 1);
    endcase
  end

  assign tick = en && !clr && (pre == last_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              pre <= '0;
    else if (clr || !en)     pre <= '0;
    else if (tick)           pre <= '0;
    else                     pre <= pre + 1'b1;
  end

  a_r2_steady_count: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && !tick) |=> (pre == $past(pre) + 1'b1));
  a_r2_tick_restart: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (pre == '0));
endmodule

// File: rtl/bp_button.sv
module bp_button #(
  parameter int LONG_PRESS = 80000000,
  parameter int CW         = 27
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic lvl_d,
  output logic short_press
);
  logic [CW-1:0] held;
  logic          released;

  assign released    = lvl_d && !lvl;
  assign short_press = released && (held < CW'(LONG_PRESS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         held <= '0;
    else if (!lvl)                      held <= '0;
    else if (held != CW'(LONG_PRESS))   held <= held + 1'b1;
  end

  a_r7_short_then_clear: assert property (@(posedge clk) disable iff (!rst_n)
    short_press |=> (held == '0));
  a_r7_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    held <= CW'(LONG_PRESS));
endmodule

// File: rtl/bp_burst_core.sv
module bp_burst_core
  import burst_pulser_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_evt,
  input  logic        stop,
  input  logic        step_tick,
  input  shape_word_t shape,
  input  burst_word_t burst,
  output logic        step_en,
  output logic        step_clr,
  output logic [1:0]  step_code_q,
  output logic        busy,
  output logic        pulse_out
);
  logic [7:0] iv_q, ht_q, cnt_q;
  logic [7:0] phase, done_cnt;
  logic       begin_evt, interval_end, end_evt;

  assign begin_evt    = start_evt && !busy && !stop;
  assign interval_end = busy && step_tick && (phase == iv_q - 8'd1);
  assign end_evt      = interval_end && (cnt_q != 8'd0) && (done_cnt == cnt_q - 8'd1);

  assign step_en   = busy;
  assign step_clr  = begin_evt;
  assign pulse_out = busy && phase_level(phase, ht_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      iv_q        <= 8'd1;
      ht_q        <= 8'd0;
      cnt_q       <= 8'd0;
      step_code_q <= 2'd0;
      phase       <= 8'd0;
      done_cnt    <= 8'd0;
    end else if (stop) begin
      busy <= 1'b0;
    end else if (begin_evt) begin
      busy        <= 1'b1;
      iv_q        <= eff_interval(shape.interval);
      ht_q        <= shape.high_time;
      cnt_q       <= burst.count;
      step_code_q <= burst.step_code;
      phase       <= 8'd0;
      done_cnt    <= 8'd0;
    end else if (busy && step_tick) begin
      if (interval_end) begin
        phase    <= 8'd0;
        done_cnt <= done_cnt + 8'd1;
        if (end_evt) busy <= 1'b0;
      end else begin
        phase <= phase + 8'd1;
      end
    end
  end

  a_r9_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !busy);
  a_r8_retrigger_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_evt && !end_evt && !stop) |=> busy);
  a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt_q != 8'd0) |-> (done_cnt < cnt_q));
  a_r3_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (phase < iv_q));
  a_r4_phase_waits_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !step_tick && !stop) |=> $stable(phase));
  a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(iv_q) && $stable(ht_q) && $stable(cnt_q) && $stable(step_code_q)));
endmodule

// File: rtl/burst_pulser.sv
module burst_pulser
  import burst_pulser_pkg::*;
#(
  parameter int STEP_DIV0  = 1,
  parameter int STEP_DIV1  = 64,
  parameter int STEP_DIV2  = 16000,
  parameter int STEP_DIV3  = 4160000,
  parameter int LONG_PRESS = 80000000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic        cfg_addr,
  input  logic [15:0] cfg_wdata,
  input  logic [1:0]  start_sel,
  input  logic        sw_start,
  input  logic        button,
  input  logic        in0,
  input  logic        in1,
  input  logic        stop_in,
  output logic        pulse_out,
  output logic        busy
);
  localparam int STEP_W = $clog2(max4(STEP_DIV0, STEP_DIV1, STEP_DIV2, STEP_DIV3) + 1);
  localparam int PRESS_W = $clog2(LONG_PRESS + 1);
  localparam int NSYNC = 4;
  localparam int I_IN0 = 0, I_IN1 = 1, I_BTN = 2, I_STOP = 3;

  shape_word_t shape_q;
  burst_word_t burst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shape_q <= '0;
      burst_q <= '0;
    end else if (cfg_we) begin
      if (!cfg_addr) shape_q <= cfg_wdata;
      else           burst_q <= {cfg_wdata[15:8], cfg_wdata[1:0]};
    end
  end

  logic [NSYNC-1:0] s_lvl, s_lvl_d;
  bp_sync_pair #(.N(NSYNC)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({stop_in, button, in1, in0}),
    .lvl   (s_lvl),
    .lvl_d (s_lvl_d)
  );

  logic rise0, rise1, short_press, manual, start_evt, stop_lvl;
  assign rise0    = s_lvl[I_IN0] && !s_lvl_d[I_IN0];
  assign rise1    = s_lvl[I_IN1] && !s_lvl_d[I_IN1];
  assign stop_lvl = s_lvl[I_STOP];

  bp_button #(.LONG_PRESS(LONG_PRESS), .CW(PRESS_W)) u_button (
    .clk         (clk),
    .rst_n       (rst_n),
    .lvl         (s_lvl[I_BTN]),
    .lvl_d       (s_lvl_d[I_BTN]),
    .short_press (short_press)
  );

  assign manual    = sw_start | short_press;
  assign start_evt = pick_start(start_src_e'(start_sel), manual, rise0, rise1);

  logic       step_tick, step_en, step_clr;
  logic [1:0] step_code_q;

  bp_step_gen #(
    .DIV0 (STEP_DIV0), .DIV1 (STEP_DIV1), .DIV2 (STEP_DIV2), .DIV3 (STEP_DIV3), .CW (STEP_W)
  ) u_step (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (step_clr),
    .en        (step_en),
    .step_code (step_code_q),
    .tick      (step_tick)
  );

  bp_burst_core u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_evt   (start_evt),
    .stop        (stop_lvl),
    .step_tick   (step_tick),
    .shape       (shape_q),
    .burst       (burst_q),
    .step_en     (step_en),
    .step_clr    (step_clr),
    .step_code_q (step_code_q),
    .busy        (busy),
    .pulse_out   (pulse_out)
  );

  a_r6_busy_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start_evt));
  a_r9_stop_holds_idle: assert property (@(posedge clk) disable iff (!rst_n)
    s_lvl_d[I_STOP] |-> (!busy && !pulse_out));
  a_r3_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !pulse_out);
endmodule

// File: tb/burst_pulser_bench.sv
module burst_pulser_bench;
  localparam int CLK_PERIOD = 10;
  localparam int D0 = 1, D1 = 3, D2 = 5, D3 = 7, LONGP = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, cfg_addr = 0;
  logic [15:0] cfg_wdata = '0;
  logic [1:0] start_sel = 2'd1;
  logic sw_start = 0, button = 0, in0 = 0, in1 = 0, stop_in = 0;
  logic pulse_out, busy;
  int n_checks = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_pulser #(.STEP_DIV0(D0), .STEP_DIV1(D1), .STEP_DIV2(D2), .STEP_DIV3(D3),
                 .LONG_PRESS(LONGP)) u_burst_pulser (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .start_sel(start_sel), .sw_start(sw_start), .button(button), .in0(in0), .in1(in1),
    .stop_in(stop_in), .pulse_out(pulse_out), .busy(busy));

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int div_of(input int code);
    case (code)
      0: return D0;
      1: return D1;
      2: return D2;
      default: return D3;
    endcase
  endfunction

  task automatic write_cfg(input logic a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setup(input int iv, input int ht, input int cnt, input int code);
    write_cfg(1'b0, {8'(iv), 8'(ht)});
    write_cfg(1'b1, {8'(cnt), 6'd0, 2'(code)});
  endtask

  // full-cycle trace of one burst started from in0 (R1 R2 R3 R4 R6 R8 R10)
  task automatic run_trace(input string req, input int iv, input int ht, input int cnt,
                           input int code, input bit retrig, input bit midwrite);
    int dv, ive, total, bad, first_c, act_b, act_p;
    setup(iv, ht, cnt, code);
    start_sel = 2'd1;
    dv = div_of(code);
    ive = (iv == 0) ? 1 : iv;
    total = cnt * ive * dv;
    bad = 0; first_c = -1; act_b = 0; act_p = 0;
    @(negedge clk); in0 = 1;
    @(negedge clk); check({req, " R6 latency edge1"}, busy, 0);
    @(negedge clk); check({req, " R6 latency edge2"}, busy, 0);
    @(negedge clk);
    for (int c = 0; c <= total; c++) begin
      int eb, ep;
      eb = (c < total) ? 1 : 0;
      ep = (eb == 1 && ((c / dv) % ive) < ht) ? 1 : 0;
      if (busy !== eb[0] || pulse_out !== ep[0]) begin
        if (first_c < 0) begin first_c = c; act_b = busy; act_p = pulse_out; end
        bad++;
      end
      if (c == 1) in0 = 0;
      if (retrig && c == 4) in0 = 1;
      if (retrig && c == 7) in0 = 0;
      if (midwrite && c == 2) begin cfg_we = 1; cfg_addr = 0; cfg_wdata = 16'h0101; end
      if (midwrite && c == 3) begin cfg_we = 1; cfg_addr = 1; cfg_wdata = 16'h0100; end
      if (midwrite && c == 4) cfg_we = 0;
      @(negedge clk);
    end
    if (first_c >= 0)
      $display("FAIL %s: first mismatch at cycle %0d busy/pulse actual %0d/%0d", req, first_c, act_b, act_p);
    n_checks++;
    if (bad != 0) n_fail++;
    idle(4);
  endtask

  task automatic stop_pulse();
    @(negedge clk); stop_in = 1;
    idle(4);
    stop_in = 0;
    idle(4);
  endtask

  task automatic test_reset();
    check("R1 reset busy", busy, 0);
    check("R1 reset pulse_out", pulse_out, 0);
  endtask

  task automatic test_continuous_and_stop();
    setup(3, 1, 0, 0);
    start_sel = 2'd1;
    @(negedge clk); in0 = 1;
    idle(3); in0 = 0;
    idle(200);
    check("R5 still busy with count 0", busy, 1);
    stop_in = 1;
    @(negedge clk); @(negedge clk);
    check("R9 busy before stop acts", busy, 1);
    @(negedge clk);
    check("R9 busy cleared by stop", busy, 0);
    check("R9 pulse_out cleared by stop", pulse_out, 0);
    in0 = 1; idle(3); in0 = 0; idle(4);
    check("R9 start ignored while stopped", busy, 0);
    stop_in = 0;
    idle(6);
    check("R9 no start after stop released", busy, 0);
  endtask

  task automatic test_sources();
    setup(2, 1, 0, 0);
    start_sel = 2'd2;
    in0 = 1; idle(3); in0 = 0; idle(4);
    check("R6 in0 ignored for source 2", busy, 0);
    in1 = 1; idle(3); in1 = 0; idle(2);
    check("R6 in1 starts for source 2", busy, 1);
    stop_pulse();
    start_sel = 2'd3;
    in1 = 1; idle(3); in1 = 0; idle(2);
    check("R6 in1 starts for source 3", busy, 1);
    stop_pulse();
    start_sel = 2'd3;
    in0 = 1; idle(3); in0 = 0; idle(2);
    check("R6 in0 starts for source 3", busy, 1);
    stop_pulse();
    start_sel = 2'd1;
    in1 = 1; idle(3); in1 = 0; idle(4);
    check("R6 in1 ignored for source 1", busy, 0);
    start_sel = 2'd1;
    sw_start = 1; @(negedge clk); sw_start = 0;
    check("R6 sw_start ignored for source 1", busy, 0);
    start_sel = 2'd0;
    in0 = 1; idle(3); in0 = 0; idle(4);
    check("R6 in0 ignored for source 0", busy, 0);
    sw_start = 1; @(negedge clk); sw_start = 0;
    check("R6 sw_start starts after one edge", busy, 1);
    stop_pulse();
  endtask

  task automatic test_button();
    setup(2, 1, 0, 0);
    start_sel = 2'd0;
    button = 1; idle(10); button = 0; idle(6);
    check("R7 short press starts burst", busy, 1);
    stop_pulse();
    button = 1; idle(LONGP + 20); button = 0; idle(10);
    check("R7 long press starts nothing", busy, 0);
    start_sel = 2'd1;
    button = 1; idle(10); button = 0; idle(6);
    check("R7 short press ignored for source 1", busy, 0);
  endtask

  initial begin
    idle(3);
    rst_n = 1;
    idle(2);
    test_reset();
    run_trace("R3 R4 base shape", 5, 2, 3, 0, 0, 0);
    run_trace("R2 step code 1", 4, 1, 2, 1, 0, 0);
    run_trace("R2 R3 code 3 wide high", 3, 5, 2, 3, 0, 0);
    run_trace("R3 interval 0 code 2", 0, 0, 4, 2, 0, 0);
    run_trace("R3 interval 0 high 1", 0, 1, 3, 0, 0, 0);
    run_trace("R8 retrigger ignored", 6, 3, 3, 0, 1, 0);
    run_trace("R10 mid-burst write", 4, 2, 3, 1, 0, 1);
    run_trace("R1 word after write", 1, 1, 1, 0, 0, 0);
    test_continuous_and_stop();
    test_sources();
    test_button();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule